// File: doc/BRIEF.md
# Raw Entropy Bit Collector with Liveness Guard

This block is the front end for a single physical noise source. Each cycle with `bit_valid` high delivers one digitized raw bit, either zero or one. The collector packs these bits into 32-bit words without any whitening or conditioning. Each finished word goes into an output queue. A downstream mixer drains that queue through a plain read port, and the port is the block's only data path toward the mixer.

A liveness monitor runs beside the packer as separate logic. It watches every raw bit the source delivers. When one bit value repeats for a programmable number of samples in a row, it treats the source as dead and raises a sticky health-fail flag. While that flag is high, completed words are thrown away instead of queued, so a stuck source cannot feed the mixer. The flag holds until a clear pulse arrives. More health tests can sit next to the monitor without any change to the packer.

When the queue is full, the finished word waits inside the packer. Raw bits that arrive during the wait are dropped, and packing resumes once a slot is free.

Top module: `entropy_collector`

## Requirements
- R1: After synchronous reset, `rd_empty` is 1, `rd_valid` is 0, `health_fail` is 0, and the next accepted bit becomes bit 0 of a new word.
- R2: Bits are stored unaltered (no whitening): the first accepted bit of a word is word bit 0, and each later accepted bit takes the next higher position, up to bit 31.
- R3: Each completed word is queued, and words leave in arrival order. A read strobe `rd_en` on a non-empty queue returns the oldest word on `rd_data`, with `rd_valid` high, on the next cycle. A strobe on an empty queue has no effect.
- R4: If the queue is full when a word completes, that word is held and arriving bits are dropped. Once a slot frees, the held word is queued, and the next accepted bit starts a fresh word at bit 0.
- R5: `health_fail` rises on the clock edge that accepts the `run_limit`-th consecutive valid bit of equal value. Runs are counted across word boundaries and include bits that the packer drops.
- R6: `health_fail` stays high until `health_clr` is pulsed. The clear takes effect on the next edge and restarts the run count from zero. A bit presented in the same cycle as the clear is not counted.
- R7: A word that completes while `health_fail` is high is discarded and never reaches the queue. Packing itself continues.
- R8: A source whose longest run of equal bits is shorter than `run_limit` never raises `health_fail`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_in | input | 1 | Raw digitized noise bit |
| bit_valid | input | 1 | `bit_in` carries a sample this cycle |
| run_limit | input | RUN_W (16) | Repeat count that declares the source dead (64 typical, at least 2) |
| health_clr | input | 1 | Pulse that clears the health flag |
| health_fail | output | 1 | Sticky liveness failure flag |
| rd_en | input | 1 | Read strobe from the mixer |
| rd_data | output | WORD_W (32) | Word returned one cycle after a read |
| rd_valid | output | 1 | `rd_data` holds a freshly read word |
| rd_empty | output | 1 | Queue holds no word |

## Verification
The embedded properties check several behaviours on every cycle. A held word and its contents stay frozen while the queue stays full. No write reaches the queue while the health flag is set. The queue occupancy never passes its depth. The flag stays set without a clear and drops after one. A read on a non-empty queue is followed by a valid strobe. Other behaviours can only be shown by the bench's scenarios, because they depend on the bit history. These are the exact bit order inside a word, that no bits are lost or altered, the exact edge on which a run reaches its limit, that bits dropped during a hold do not corrupt the following word, and which particular word is discarded once the flag is set.

// File: rtl/entropy_pkg.sv
package entropy_pkg;
  localparam int unsigned WORD_BITS    = 32;
  localparam int unsigned QUEUE_DEPTH  = 4;
  localparam int unsigned RUN_BITS     = 16;
  localparam int unsigned DEFAULT_RUN  = 64;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/bit_packer.sv
module bit_packer #(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_in,
  input  logic              bit_valid,
  input  logic              q_full,
  input  logic              drop_words,
  output logic              q_wr,
  output logic [WORD_W-1:0] q_wdata
);
  localparam int unsigned CW = entropy_pkg::idx_width(WORD_W);
  localparam logic [CW-1:0] LAST_POS = CW'(WORD_W - 1);

  logic [WORD_W-1:0] acc;
  logic [CW-1:0]     pos;
  logic              pending;
  logic              drain;
  logic              take;

  // a finished word leaves the packer when it may be written or must be dropped
  assign drain   = pending && (drop_words || !q_full);
  assign take    = bit_valid && (!pending || drain);
  assign q_wr    = pending && !drop_words && !q_full;
  assign q_wdata = acc;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc     <= '0;
      pos     <= '0;
      pending <= 1'b0;
    end else begin
      if (drain) pending <= 1'b0;
      if (take) begin
        acc[pos] <= bit_in;
        if (pos == LAST_POS) begin
          pos     <= '0;
          pending <= 1'b1;
        end else begin
          pos <= pos + 1'b1;
        end
      end
    end
  end

  // R4: a held word is frozen while the queue stays full
  p_hold_word_r4: assert property (@(posedge clk) disable iff (rst)
    (pending && q_full && !drop_words) |=> (pending && $stable(acc)));

  // R7: nothing is written while the health flag is raised
  p_no_write_on_fail_r7: assert property (@(posedge clk) disable iff (rst)
    drop_words |-> !q_wr);
endmodule

// File: rtl/run_monitor.sv
module run_monitor #(
  parameter int unsigned RUN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_in,
  input  logic             bit_valid,
  input  logic [RUN_W-1:0] limit,
  input  logic             clr,
  output logic             fail
);
  localparam logic [RUN_W-1:0] RUN_MAX = '1;

  logic             last_bit;
  logic             seen;
  logic [RUN_W-1:0] run_len;
  logic [RUN_W-1:0] run_next;

  always_comb begin
    if (seen && (bit_in == last_bit))
      run_next = (run_len == RUN_MAX) ? run_len : run_len + 1'b1;
    else
      run_next = RUN_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      last_bit <= 1'b0;
      seen     <= 1'b0;
      run_len  <= '0;
      fail     <= 1'b0;
    end else if (clr) begin
      seen    <= 1'b0;
      run_len <= '0;
      fail    <= 1'b0;
    end else if (bit_valid) begin
      last_bit <= bit_in;
      seen     <= 1'b1;
      run_len  <= run_next;
      if (run_next >= limit) fail <= 1'b1;
    end
  end

  // R6: the flag is sticky without a clear
  p_fail_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (fail && !clr) |=> fail);

  // R6: a clear drops the flag on the next edge
  p_clear_works_r6: assert property (@(posedge clk) disable iff (rst)
    clr |=> !fail);

  // R5: the flag only rises on a counted sample
  p_rise_on_sample_r5: assert property (@(posedge clk) disable iff (rst)
    (!fail && !bit_valid) |=> !fail);
endmodule

// File: rtl/word_queue.sv
module word_queue #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [WORD_W-1:0] wdata,
  output logic              full,
  input  logic              rd,
  output logic [WORD_W-1:0] rdata,
  output logic              rvalid,
  output logic              empty
);
  localparam int unsigned AW = entropy_pkg::idx_width(DEPTH);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [AW:0]       wp;
  logic [AW:0]       rp;
  logic [AW:0]       used;
  logic              do_wr;
  logic              do_rd;

  assign used  = wp - rp;
  assign empty = (wp == rp);
  assign full  = (used == (AW+1)'(DEPTH));
  assign do_wr = wr && !full;
  assign do_rd = rd && !empty;

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp[AW-1:0]] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (do_rd) rdata <= mem[rp[AW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp     <= '0;
      rp     <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= do_rd;
      if (do_wr) wp <= wp + 1'b1;
      if (do_rd) rp <= rp + 1'b1;
    end
  end

  // R4: occupancy never exceeds the depth
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
    used <= (AW+1)'(DEPTH));

  // R3: a read on a non-empty queue yields a valid word next cycle
  p_read_returns_r3: assert property (@(posedge clk) disable iff (rst)
    (rd && !empty) |=> rvalid);

  // R3: a read on an empty queue returns nothing
  p_empty_read_r3: assert property (@(posedge clk) disable iff (rst)
    (!rd || empty) |=> !rvalid);
endmodule

// File: rtl/entropy_collector.sv
module entropy_collector #(
  parameter int unsigned WORD_W = entropy_pkg::WORD_BITS,
  parameter int unsigned DEPTH  = entropy_pkg::QUEUE_DEPTH,
  parameter int unsigned RUN_W  = entropy_pkg::RUN_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_in,
  input  logic              bit_valid,
  input  logic [RUN_W-1:0]  run_limit,
  input  logic              health_clr,
  output logic              health_fail,
  input  logic              rd_en,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              rd_empty
);
  logic              q_full;
  logic              q_wr;
  logic [WORD_W-1:0] q_wdata;

  run_monitor #(.RUN_W(RUN_W)) u_monitor (
    .clk      (clk),
    .rst      (rst),
    .bit_in   (bit_in),
    .bit_valid(bit_valid),
    .limit    (run_limit),
    .clr      (health_clr),
    .fail     (health_fail)
  );

  bit_packer #(.WORD_W(WORD_W)) u_packer (
    .clk       (clk),
    .rst       (rst),
    .bit_in    (bit_in),
    .bit_valid (bit_valid),
    .q_full    (q_full),
    .drop_words(health_fail),
    .q_wr      (q_wr),
    .q_wdata   (q_wdata)
  );

  word_queue #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_queue (
    .clk   (clk),
    .rst   (rst),
    .wr    (q_wr),
    .wdata (q_wdata),
    .full  (q_full),
    .rd    (rd_en),
    .rdata (rd_data),
    .rvalid(rd_valid),
    .empty (rd_empty)
  );
endmodule

// File: tb/entropy_collector_test.sv
module entropy_collector_test;
  localparam int unsigned DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bit_in = 1'b0;
  logic        bit_valid = 1'b0;
  logic [15:0] run_limit = 16'd64;
  logic        health_clr = 1'b0;
  logic        health_fail;
  logic        rd_en = 1'b0;
  logic [31:0] rd_data;
  logic        rd_valid;
  logic        rd_empty;

  int checks = 0;
  int fails  = 0;

  entropy_collector #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst(rst), .bit_in(bit_in), .bit_valid(bit_valid),
    .run_limit(run_limit), .health_clr(health_clr), .health_fail(health_fail),
    .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid), .rd_empty(rd_empty)
  );

  always #10 clk = ~clk;

  localparam logic [31:0] VEC [8] = '{
    32'h0000_0001, 32'h8000_0000, 32'hA5A5_A5A5, 32'h1234_5678,
    32'hFFFF_0000, 32'h0F0F_0F0F, 32'hDEAD_BEEF, 32'h1357_9BDF
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send_bits(input logic [31:0] w, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bit_in    = w[i];
      bit_valid = 1'b1;
    end
    @(negedge clk);
    bit_valid = 1'b0;
  endtask

  task automatic read_word(output logic [31:0] w, output logic v);
    @(negedge clk);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    w = rd_data;
    v = rd_valid;
  endtask

  task automatic pulse_clear();
    @(negedge clk);
    health_clr = 1'b1;
    @(negedge clk);
    health_clr = 1'b0;
  endtask

  initial begin
    #4_000_000;
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] got;
    logic        v;
    idle(3);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(rd_empty == 1'b1, "R1 empty", {31'd0, rd_empty}, 32'd1);
    check(rd_valid == 1'b0, "R1 valid", {31'd0, rd_valid}, 32'd0);
    check(health_fail == 1'b0, "R1 fail", {31'd0, health_fail}, 32'd0);
    read_word(got, v);
    check(v == 1'b0, "R3 empty read ignored", {31'd0, v}, 32'd0);

    // R2/R3 table walk
    for (int i = 0; i < 8; i++) begin
      send_bits(VEC[i], 32);
      idle(1);
      read_word(got, v);
      check(v && got == VEC[i], "R2 bit order", got, VEC[i]);
    end
    check(rd_empty == 1'b1, "R3 drained", {31'd0, rd_empty}, 32'd1);

    // R4 queue full hold and drop
    pulse_clear();
    for (int i = 0; i < DEPTH; i++) send_bits(VEC[i+2], 32);
    idle(2);
    send_bits(32'h3C3C_C3C3, 32);
    send_bits(32'h0000_00AA, 8);
    for (int i = 0; i < DEPTH; i++) begin
      read_word(got, v);
      check(v && got == VEC[i+2], "R3 order under full", got, VEC[i+2]);
    end
    idle(2);
    read_word(got, v);
    check(v && got == 32'h3C3C_C3C3, "R4 held word", got, 32'h3C3C_C3C3);
    send_bits(32'h6996_9669, 32);
    idle(1);
    read_word(got, v);
    check(v && got == 32'h6996_9669, "R4 fresh word at bit 0", got, 32'h6996_9669);

    // R5/R7 stuck-at-zero source, limit 64
    pulse_clear();
    send_bits(32'h0, 32);
    check(health_fail == 1'b0, "R8 below limit", {31'd0, health_fail}, 32'd0);
    send_bits(32'h0, 31);
    check(health_fail == 1'b0, "R5 at 63", {31'd0, health_fail}, 32'd0);
    send_bits(32'h0, 1);
    check(health_fail == 1'b1, "R5 at 64", {31'd0, health_fail}, 32'd1);
    idle(1);
    read_word(got, v);
    check(v && got == 32'h0, "R7 pre-fail word kept", got, 32'h0);
    idle(2);
    check(rd_empty == 1'b1, "R7 failing word discarded", {31'd0, rd_empty}, 32'd1);

    // R6 sticky, R7 continued discard
    send_bits(32'h5555_5555, 32);
    idle(2);
    check(health_fail == 1'b1, "R6 sticky", {31'd0, health_fail}, 32'd1);
    check(rd_empty == 1'b1, "R7 discard while failed", {31'd0, rd_empty}, 32'd1);
    pulse_clear();
    check(health_fail == 1'b0, "R6 cleared", {31'd0, health_fail}, 32'd0);
    send_bits(32'hC0FF_EE11, 32);
    idle(1);
    read_word(got, v);
    check(v && got == 32'hC0FF_EE11, "R6 words flow after clear", got, 32'hC0FF_EE11);

    // R8/R5 programmable limit 8
    run_limit = 16'd8;
    pulse_clear();
    send_bits(32'h7F7F_7F7F, 32);
    idle(1);
    check(health_fail == 1'b0, "R8 runs of 7", {31'd0, health_fail}, 32'd0);
    read_word(got, v);
    check(v && got == 32'h7F7F_7F7F, "R8 word kept", got, 32'h7F7F_7F7F);
    send_bits(32'h5555_5500, 32);
    idle(2);
    check(health_fail == 1'b1, "R5 limit 8", {31'd0, health_fail}, 32'd1);
    check(rd_empty == 1'b1, "R7 discard at limit 8", {31'd0, rd_empty}, 32'd1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule